// File: doc/BRIEF.md
# Shared Buffer Channel Controller

This block owns a pool of shared word buffers that processing elements use as one-to-many communication channels. A producer opens a channel with a command naming itself and a bitmap of consumers. The controller claims a free buffer and sends one routing message to each element in the channel, so all of them point at that buffer. Adding a consumer costs one more routing message and nothing else. An element's reads and writes through the shared ports are held back until its own routing entry has been written.

Each buffer word carries a valid flag. A producer write sets the flag. A consumer read of a word that has not been written gets a data-less INVALID reply, and the consumer retries later at a gap of its own choosing. The producer closes the channel and each consumer ends its use. Each of these commands removes the sender's routing entry. Once the close and every expected end have arrived, the buffer goes back to the pool with all its valid flags cleared. If an open arrives while every buffer is in use, it is parked until a buffer is released.

Top module: `sbc_top`

## Requirements
- R1: After reset every buffer is free and no element has a routing entry. `cmd_ready` is high, and `cfg_valid` and `rsp_valid` are low.
- R2: An accepted open (`cmd_op`=1) claims the lowest-numbered free buffer. In the following cycles it issues one routing message per cycle, with `cfg_set`=1 and `cfg_buf` set to that buffer. The messages go to the producer and to each element in `cmd_cons`, in ascending element index.
- R3: An open accepted while all buffers are busy issues no routing message and leaves the producer held. Once a buffer is released, the parked open goes ahead by itself on the lowest free buffer.
- R4: A write from an element with no producer routing entry raises `wr_held` in the same cycle and stores nothing. A read from an element with no consumer routing entry is answered with `rsp_code`=3 (HELD).
- R5: A write accepted from the producer stores the data and marks that word valid. `wr_held` stays low for it.
- R6: Each read receives a response in the next cycle. A word not yet valid gives `rsp_code`=2 (INVALID) with `rsp_data` zero. A valid word gives `rsp_code`=1 (DATA) with the stored data.
- R7: A close (`cmd_op`=2) from the producer, or an end (`cmd_op`=3) from a consumer, issues one routing message with `cfg_set`=0 to the sender. After that message, the sender's accesses are held.
- R8: A buffer returns to the pool only after its close and every expected end have arrived, in any order. A later channel on the same buffer reads every word as INVALID until it is written again.
- R9: A close from an element that is not a producer, or an end from an element that is not a consumer, is ignored. It issues no message and leaves all routes intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 1 open, 2 close, 3 end |
| cmd_src | input | PW | Sending element |
| cmd_cons | input | NPE | Consumer bitmap for open |
| cmd_ready | output | 1 | Command accepted this cycle when high |
| cfg_valid | output | 1 | Routing message issued |
| cfg_pe | output | PW | Target element of the message |
| cfg_buf | output | BW | Buffer the entry points at |
| cfg_set | output | 1 | 1 programs the entry, 0 removes it |
| wr_valid | input | 1 | Write request |
| wr_pe | input | PW | Writing element |
| wr_addr | input | AW | Word address in the buffer |
| wr_data | input | DW | Write data |
| wr_held | output | 1 | Write refused this cycle |
| rd_valid | input | 1 | Read request |
| rd_pe | input | PW | Reading element |
| rd_addr | input | AW | Word address in the buffer |
| rsp_valid | output | 1 | Read response present |
| rsp_code | output | 2 | 1 DATA, 2 INVALID, 3 HELD |
| rsp_data | output | DW | Read data, zero unless DATA |

## Verification
The assertions check on every cycle the properties that are local in time. A DATA reply only ever comes from a word whose valid flag was set. Every accepted write comes from an element with a producer route. A released buffer holds no valid flag one cycle later. A programming message always names a claimed buffer, and an open that meets a full pool is parked and sends no message. Only the directed scenarios can show the behaviour that spans many cycles and commands. These include the message order across producer and consumers, and the refusal of commands from the wrong role. They also cover a release that waits for the last end, the automatic start of a parked open, and the INVALID replies seen when a buffer is reused.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam logic [1:0] OP_OPEN  = 2'd1;
  localparam logic [1:0] OP_CLOSE = 2'd2;
  localparam logic [1:0] OP_END   = 2'd3;

  localparam logic [1:0] RSP_NONE  = 2'd0;
  localparam logic [1:0] RSP_DATA  = 2'd1;
  localparam logic [1:0] RSP_INVAL = 2'd2;
  localparam logic [1:0] RSP_HELD  = 2'd3;

  typedef enum logic {S_IDLE, S_CFG} ctrl_state_e;
endpackage

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
#(
  parameter int NPE  = 16,
  parameter int NBUF = 8,
  localparam int PW = $clog2(NPE),
  localparam int BW = $clog2(NBUF)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [PW-1:0]            cmd_src,
  input  logic [NPE-1:0]           cmd_cons,
  output logic                     cmd_ready,
  output logic                     cfg_valid,
  output logic [PW-1:0]            cfg_pe,
  output logic [BW-1:0]            cfg_buf,
  output logic                     cfg_set,
  output logic [NPE-1:0]           rt_valid,
  output logic [NPE-1:0]           rt_prod,
  output logic [NPE-1:0][BW-1:0]   rt_buf,
  output logic                     rel_valid,
  output logic [BW-1:0]            rel_buf
);
  function automatic logic [BW-1:0] first_free(input logic [NBUF-1:0] b);
    logic [BW-1:0] r = '0;
    for (int i = NBUF-1; i >= 0; i--) if (!b[i]) r = BW'(i);
    return r;
  endfunction

  function automatic logic [BW-1:0] first_set_buf(input logic [NBUF-1:0] b);
    logic [BW-1:0] r = '0;
    for (int i = NBUF-1; i >= 0; i--) if (b[i]) r = BW'(i);
    return r;
  endfunction

  function automatic logic [PW-1:0] first_pe(input logic [NPE-1:0] m);
    logic [PW-1:0] r = '0;
    for (int i = NPE-1; i >= 0; i--) if (m[i]) r = PW'(i);
    return r;
  endfunction

  function automatic logic [NPE-1:0] pe_bit(input logic [PW-1:0] p);
    logic [NPE-1:0] r = '0;
    r[p] = 1'b1;
    return r;
  endfunction

  ctrl_state_e               st;
  logic [NBUF-1:0]           busy, closed;
  logic [NBUF-1:0][NPE-1:0]  waitend;
  logic [NPE-1:0]            walk;
  logic [BW-1:0]             walk_buf;
  logic                      walk_set;
  logic [PW-1:0]             walk_prod;
  logic                      po_valid;
  logic [PW-1:0]             po_src;
  logic [NPE-1:0]            po_cons;

  // named internal events
  logic            any_free, start_po, take, do_open, park, close_ok, end_ok;
  logic [PW-1:0]   open_src;
  logic [NPE-1:0]  open_cons;
  logic [BW-1:0]   pick, src_buf;
  logic [NBUF-1:0] rel_hit;

  always_comb begin
    any_free  = ~&busy;
    start_po  = (st == S_IDLE) && po_valid && any_free;
    cmd_ready = (st == S_IDLE) && !start_po && !((cmd_op == OP_OPEN) && po_valid);
    take      = cmd_valid && cmd_ready;
    do_open   = start_po || (take && cmd_op == OP_OPEN && any_free);
    park      = take && cmd_op == OP_OPEN && !any_free;
    close_ok  = take && cmd_op == OP_CLOSE && rt_valid[cmd_src] && rt_prod[cmd_src];
    end_ok    = take && cmd_op == OP_END && rt_valid[cmd_src] && !rt_prod[cmd_src];
    open_src  = start_po ? po_src : cmd_src;
    open_cons = start_po ? po_cons : cmd_cons;
    pick      = first_free(busy);
    src_buf   = rt_buf[cmd_src];
    for (int b = 0; b < NBUF; b++)
      rel_hit[b] = busy[b] && closed[b] && (waitend[b] == '0);
    rel_valid = (st == S_IDLE) && (|rel_hit);
    rel_buf   = first_set_buf(rel_hit);
    cfg_valid = (st == S_CFG);
    cfg_pe    = first_pe(walk);
    cfg_buf   = walk_buf;
    cfg_set   = walk_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      busy <= '0; closed <= '0; waitend <= '0;
      walk <= '0; walk_buf <= '0; walk_set <= 1'b0; walk_prod <= '0;
      po_valid <= 1'b0; po_src <= '0; po_cons <= '0;
      rt_valid <= '0; rt_prod <= '0; rt_buf <= '0;
    end else begin
      if (rel_valid) begin
        busy[rel_buf]   <= 1'b0;
        closed[rel_buf] <= 1'b0;
      end
      if (do_open) begin
        busy[pick]    <= 1'b1;
        closed[pick]  <= 1'b0;
        waitend[pick] <= open_cons & ~pe_bit(open_src);
        walk          <= open_cons | pe_bit(open_src);
        walk_buf      <= pick;
        walk_set      <= 1'b1;
        walk_prod     <= open_src;
        st            <= S_CFG;
        if (start_po) po_valid <= 1'b0;
      end
      if (park) begin
        po_valid <= 1'b1;
        po_src   <= cmd_src;
        po_cons  <= cmd_cons;
      end
      if (close_ok || end_ok) begin
        if (close_ok) closed[src_buf] <= 1'b1;
        if (end_ok) waitend[src_buf][cmd_src] <= 1'b0;
        walk     <= pe_bit(cmd_src);
        walk_buf <= src_buf;
        walk_set <= 1'b0;
        st       <= S_CFG;
      end
      if (st == S_CFG) begin
        rt_valid[cfg_pe] <= walk_set;
        rt_prod[cfg_pe]  <= walk_set && (cfg_pe == walk_prod);
        rt_buf[cfg_pe]   <= walk_buf;
        walk[cfg_pe]     <= 1'b0;
        if (walk == pe_bit(cfg_pe)) st <= S_IDLE;
      end
    end
  end

  // R3: an open meeting a full pool is parked and sends nothing
  p_full_parks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == OP_OPEN && (&busy)) |=> (!cfg_valid && po_valid));

  // R2: a programming message always names a claimed buffer
  p_cfg_claimed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_set) |-> busy[cfg_buf]);
endmodule

// File: rtl/sbc_store.sv
module sbc_store
  import sbc_pkg::*;
#(
  parameter int NPE   = 16,
  parameter int NBUF  = 8,
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int PW = $clog2(NPE),
  localparam int BW = $clog2(NBUF),
  localparam int AW = $clog2(DEPTH),
  localparam int NW = NBUF * DEPTH,
  localparam int WI = $clog2(NW)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPE-1:0]          rt_valid,
  input  logic [NPE-1:0]          rt_prod,
  input  logic [NPE-1:0][BW-1:0]  rt_buf,
  input  logic                    rel_valid,
  input  logic [BW-1:0]           rel_buf,
  input  logic                    wr_valid,
  input  logic [PW-1:0]           wr_pe,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  output logic                    wr_held,
  input  logic                    rd_valid,
  input  logic [PW-1:0]           rd_pe,
  input  logic [AW-1:0]           rd_addr,
  output logic                    rsp_valid,
  output logic [1:0]              rsp_code,
  output logic [DW-1:0]           rsp_data
);
  function automatic logic [WI-1:0] word_of(input logic [BW-1:0] b, input logic [AW-1:0] a);
    return WI'(b) * WI'(DEPTH) + WI'(a);
  endfunction

  function automatic logic any_valid(input logic [NW-1:0] v, input logic [BW-1:0] b);
    logic r = 1'b0;
    for (int w = 0; w < NW; w++) if ((w / DEPTH) == int'(b) && v[w]) r = 1'b1;
    return r;
  endfunction

  logic [DW-1:0] mem [NW];
  logic [NW-1:0] vbit;
  logic          wr_ok, rd_ok;
  logic [WI-1:0] wr_word, rd_word;

  always_comb begin
    wr_ok   = wr_valid && rt_valid[wr_pe] && rt_prod[wr_pe];
    rd_ok   = rd_valid && rt_valid[rd_pe] && !rt_prod[rd_pe];
    wr_held = wr_valid && !wr_ok;
    wr_word = word_of(rt_buf[wr_pe], wr_addr);
    rd_word = word_of(rt_buf[rd_pe], rd_addr);
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_word] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vbit <= '0;
    end else begin
      for (int w = 0; w < NW; w++)
        if (rel_valid && (w / DEPTH) == int'(rel_buf)) vbit[w] <= 1'b0;
      if (wr_ok) vbit[wr_word] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_NONE;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_valid;
      rsp_data  <= '0;
      if (!rd_valid)            rsp_code <= RSP_NONE;
      else if (!rd_ok)          rsp_code <= RSP_HELD;
      else if (!vbit[rd_word])  rsp_code <= RSP_INVAL;
      else begin
        rsp_code <= RSP_DATA;
        rsp_data <= mem[rd_word];
      end
    end
  end

  // R6: DATA only from a word whose flag was set
  p_data_only_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == RSP_DATA) |-> $past(vbit[rd_word]));

  // R5: stored writes only come from a producer route
  p_write_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_held) |-> (rt_valid[wr_pe] && rt_prod[wr_pe]));

  // R8: a released buffer is left with no valid word
  p_release_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |=> !any_valid(vbit, $past(rel_buf)));
endmodule

// File: rtl/sbc_top.sv
module sbc_top
  import sbc_pkg::*;
#(
  parameter int NPE   = 16,
  parameter int NBUF  = 8,
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int PW = $clog2(NPE),
  localparam int BW = $clog2(NBUF),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [1:0]     cmd_op,
  input  logic [PW-1:0]  cmd_src,
  input  logic [NPE-1:0] cmd_cons,
  output logic           cmd_ready,
  output logic           cfg_valid,
  output logic [PW-1:0]  cfg_pe,
  output logic [BW-1:0]  cfg_buf,
  output logic           cfg_set,
  input  logic           wr_valid,
  input  logic [PW-1:0]  wr_pe,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic           wr_held,
  input  logic           rd_valid,
  input  logic [PW-1:0]  rd_pe,
  input  logic [AW-1:0]  rd_addr,
  output logic           rsp_valid,
  output logic [1:0]     rsp_code,
  output logic [DW-1:0]  rsp_data
);
  logic [NPE-1:0]         rt_valid, rt_prod;
  logic [NPE-1:0][BW-1:0] rt_buf;
  logic                   rel_valid;
  logic [BW-1:0]          rel_buf;

  sbc_ctrl #(.NPE(NPE), .NBUF(NBUF)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_src(cmd_src), .cmd_cons(cmd_cons),
    .cmd_ready(cmd_ready),
    .cfg_valid(cfg_valid), .cfg_pe(cfg_pe), .cfg_buf(cfg_buf), .cfg_set(cfg_set),
    .rt_valid(rt_valid), .rt_prod(rt_prod), .rt_buf(rt_buf),
    .rel_valid(rel_valid), .rel_buf(rel_buf)
  );

  sbc_store #(.NPE(NPE), .NBUF(NBUF), .DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rt_valid(rt_valid), .rt_prod(rt_prod), .rt_buf(rt_buf),
    .rel_valid(rel_valid), .rel_buf(rel_buf),
    .wr_valid(wr_valid), .wr_pe(wr_pe), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_held(wr_held),
    .rd_valid(rd_valid), .rd_pe(rd_pe), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_data(rsp_data)
  );
endmodule

// File: tb/tb_sbc_top.sv
module tb_sbc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [3:0]  cmd_src;
  logic [15:0] cmd_cons;
  logic        cmd_ready;
  logic        cfg_valid;
  logic [3:0]  cfg_pe;
  logic [2:0]  cfg_buf;
  logic        cfg_set;
  logic        wr_valid;
  logic [3:0]  wr_pe;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic        wr_held;
  logic        rd_valid;
  logic [3:0]  rd_pe;
  logic [3:0]  rd_addr;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [15:0] rsp_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  sbc_top dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [1:0] op, input int src, input logic [15:0] cons);
    cmd_valid = 1'b1; cmd_op = op; cmd_src = 4'(src); cmd_cons = cons;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic expect_msg(input string tag, input int pe, input int bidx, input int set);
    chk({tag, " msg present"}, cfg_valid, 1);
    chk({tag, " msg element"}, cfg_pe, pe);
    chk({tag, " msg buffer"}, cfg_buf, bidx);
    chk({tag, " msg kind"}, cfg_set, set);
    @(negedge clk);
  endtask

  task automatic expect_quiet(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      chk({tag, " no msg"}, cfg_valid, 0);
      @(negedge clk);
    end
  endtask

  task automatic wait_msg();
    for (int i = 0; i < 10 && !cfg_valid; i++) @(negedge clk);
  endtask

  task automatic wr_op(input string tag, input int pe, input int a, input int d, input int held);
    wr_valid = 1'b1; wr_pe = 4'(pe); wr_addr = 4'(a); wr_data = 16'(d);
    #1;
    chk({tag, " wr_held"}, wr_held, held);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd_op(input string tag, input int pe, input int a, input int code, input int d);
    rd_valid = 1'b1; rd_pe = 4'(pe); rd_addr = 4'(a);
    @(negedge clk);
    chk({tag, " rsp_valid"}, rsp_valid, 1);
    chk({tag, " rsp_code"}, rsp_code, code);
    chk({tag, " rsp_data"}, rsp_data, (code == 1) ? d : 0);
    rd_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cmd_valid = 0; cmd_op = 0; cmd_src = 0; cmd_cons = 0;
    wr_valid = 0; wr_pe = 0; wr_addr = 0; wr_data = 0;
    rd_valid = 0; rd_pe = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cmd_ready", cmd_ready, 1);
    chk("R1 cfg_valid", cfg_valid, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
  endtask

  // open producer 1 with consumers 0 and 2
  task automatic t_open_and_gate();
    wr_op("R4 write before route", 1, 5, 16'h1234, 1);
    rd_op("R4 read before route", 0, 5, 3, 0);
    send_cmd(2'd1, 1, 16'b0101);
    expect_msg("R2 first", 0, 0, 1);
    expect_msg("R2 second", 1, 0, 1);
    expect_msg("R2 third", 2, 0, 1);
    rd_op("R4 held write stored nothing", 0, 5, 2, 0);
  endtask

  task automatic t_valid_flags();
    rd_op("R6 unwritten word", 2, 5, 2, 0);
    repeat (3) @(negedge clk);
    rd_op("R6 retry still unwritten", 2, 5, 2, 0);
    wr_op("R5 producer write", 1, 5, 16'hBEEF, 0);
    rd_op("R6 consumer 0 data", 0, 5, 1, 16'hBEEF);
    rd_op("R6 consumer 2 data", 2, 5, 1, 16'hBEEF);
    wr_op("R4 consumer write refused", 0, 6, 16'h7777, 1);
    rd_op("R4 producer read refused", 1, 5, 3, 0);
    rd_op("R4 refused write left word", 0, 6, 2, 0);
  endtask

  task automatic t_ignored_cmds();
    send_cmd(2'd3, 1, 16'h0);
    expect_quiet("R9 end from producer", 3);
    wr_op("R9 producer route kept", 1, 7, 16'h1111, 0);
    send_cmd(2'd2, 0, 16'h0);
    expect_quiet("R9 close from consumer", 3);
    rd_op("R9 consumer route kept", 0, 7, 1, 16'h1111);
  endtask

  task automatic t_full_pool();
    for (int p = 4; p <= 10; p++) begin
      send_cmd(2'd1, p, 16'h0);
      expect_msg("R2 fill", p, p - 3, 1);
    end
    send_cmd(2'd1, 11, 16'h0);
    expect_quiet("R3 parked open", 4);
    wr_op("R3 parked producer held", 11, 2, 16'h4444, 1);
    send_cmd(2'd2, 4, 16'h0);
    expect_msg("R7 close", 4, 1, 0);
    wr_op("R7 closed producer held", 4, 2, 16'h4444, 1);
    wait_msg();
    expect_msg("R3 parked open resumes", 11, 1, 1);
    wr_op("R3 resumed producer writes", 11, 2, 16'hAAAA, 0);
  endtask

  task automatic t_release_order();
    send_cmd(2'd3, 2, 16'h0);
    expect_msg("R7 end", 2, 0, 0);
    rd_op("R7 ended consumer held", 2, 5, 3, 0);
    rd_op("R8 other consumer keeps data", 0, 5, 1, 16'hBEEF);
    send_cmd(2'd2, 1, 16'h0);
    expect_msg("R7 close", 1, 0, 0);
    send_cmd(2'd1, 12, 16'h2000);
    expect_quiet("R8 not released before last end", 4);
    send_cmd(2'd3, 0, 16'h0);
    expect_msg("R7 last end", 0, 0, 0);
    wait_msg();
    expect_msg("R8 reuse producer", 12, 0, 1);
    expect_msg("R8 reuse consumer", 13, 0, 1);
    rd_op("R8 flags cleared on reuse", 13, 5, 2, 0);
    wr_op("R5 new producer write", 12, 5, 16'h5A5A, 0);
    rd_op("R6 new channel data", 13, 5, 1, 16'h5A5A);
  endtask

  initial begin
    t_reset();
    t_open_and_gate();
    t_valid_flags();
    t_ignored_cmds();
    t_full_pool();
    t_release_order();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule